// File: doc/BRIEF.md
# PCI DMA Address Window Decoder

This block sits on the inbound side of a host bridge. It takes the address of a DMA cycle that a PCI device starts and checks it against four programmable windows into main memory. Each window has a fixed role. Window 0 carries DMA from the legacy expansion bus. Window 1 is handed to a scatter/gather translator. Window 2 maps a contiguous PCI range straight onto a contiguous stretch of memory. Window 3 is reserved for dual-address (64-bit) cycles, so that memory above 4 GB can be reached.

The result is registered and appears one clock after the request strobe. It gives the winning window's index, a hit or no-hit flag, a flag that sends the cycle on to the scatter/gather translator, and a memory address. For a direct window the memory address is the window's translated base plus the offset inside the window. For the scatter/gather window it is the raw offset. On a no-hit, the bridge leaves the cycle unclaimed. Software programs each window with an enable bit, a base, an offset mask (ones mark the offset bits) and a translated base.

Top module: `pciwin_decoder`

## Requirements
- R1: While reset is asserted, and after it is released, outValid, outHit, outNoHit and outFwdSg are 0, outWinIdx is 0 and outMemAddr is 0.
- R2: outValid is 1 in exactly the cycle after a cycle with reqValid high, and 0 otherwise.
- R3: Window w matches when winEnable[w] is 1 and the effective address equals winBase, comparing only the bits where winMask is 0. A disabled window never matches.
- R4: When several windows match, outWinIdx reports the lowest-numbered one.
- R5: With reqDac=0 the effective address is reqAddr[31:0] zero-extended, and bits 63:32 have no effect; window 3 cannot match. With reqDac=1 the full 64-bit reqAddr is used, and only window 3 can match.
- R6: A hit in window 0, 2 or 3 gives outFwdSg=0 and outMemAddr = (winXlate + (effective address AND winMask)) modulo 2^40, using bits 39:0.
- R7: A hit in window 1 gives outFwdSg=1 and outMemAddr = effective address AND winMask, bits 39:0.
- R8: A valid result with no match gives outNoHit=1, outHit=0, outFwdSg=0, outWinIdx=0 and outMemAddr=0. outHit and outNoHit are never both 1.
- R9: In a cycle with outValid=0, outHit, outNoHit and outFwdSg are 0, and outWinIdx and outMemAddr keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe: an address is presented this cycle |
| reqDac | input | 1 | 1 = dual-address (64-bit) cycle, 0 = single-address cycle |
| reqAddr | input | 64 | PCI address |
| winEnable | input | 4 | Per-window enable, bit w for window w |
| winBase | input | 256 | Window bases, window w in bits [64w+63:64w] |
| winMask | input | 256 | Window offset masks (1 = offset bit), same packing |
| winXlate | input | 256 | Translated memory bases, same packing |
| outValid | output | 1 | Result valid (one cycle after reqValid) |
| outHit | output | 1 | Some window matched |
| outNoHit | output | 1 | No window matched; cycle must not be claimed |
| outFwdSg | output | 1 | Hit in the scatter/gather window |
| outWinIdx | output | 2 | Index of the winning window |
| outMemAddr | output | 40 | Direct memory address, or window offset for scatter/gather |

## Verification
Directed requests place overlapping windows 1 and 2 so that the address decides which one wins. They then disable one window to expose the next, and send the same low 32 bits with and without the dual-address flag, with garbage in the upper half, to separate 32-bit and 64-bit handling. Next comes a long random stream. It mixes idle cycles, addresses aimed inside each window, addresses aimed outside all of them, and enable changes mid-stream. Every cycle of that stream is compared with a behavioural model, so no-hit, forwarding, offset arithmetic and hold behaviour are all tried against many different offsets.

// File: rtl/pciwin_pkg.sv
`timescale 1ns/1ps
package pciwin_pkg;
  localparam int NUM_WIN  = 4;
  localparam int IDX_W    = $clog2(NUM_WIN);
  localparam int WIN_SG   = 1;  // forwarded to the scatter/gather translator
  localparam int WIN_WIDE = 3;  // dual-address cycles only
  localparam int LOW_AW   = 32;

  typedef struct packed {
    logic             load;
    logic             hit;
    logic [IDX_W-1:0] winIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/pciwin_datapath.sv
`timescale 1ns/1ps
module pciwin_datapath
  import pciwin_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int MEM_W  = 40
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqDac,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [NUM_WIN-1:0]        winEnable,
  input  logic [NUM_WIN*ADDR_W-1:0] winBase,
  input  logic [NUM_WIN*ADDR_W-1:0] winMask,
  input  logic [NUM_WIN*ADDR_W-1:0] winXlate,
  input  ctrlStrobe_t               strobe,
  output logic [NUM_WIN-1:0]        matchVec,
  output logic [MEM_W-1:0]          memAddr
);
  localparam int HI_W = ADDR_W - LOW_AW;

  logic [ADDR_W-1:0] effAddr;
  logic [MEM_W-1:0]  mapped [NUM_WIN];
  logic [MEM_W-1:0]  memNext;

  // single-address cycles carry only the low word
  assign effAddr = reqDac ? reqAddr : {{HI_W{1'b0}}, reqAddr[LOW_AW-1:0]};

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [ADDR_W-1:0] baseW;
    logic [ADDR_W-1:0] maskW;
    logic [MEM_W-1:0]  xlW;
    logic [MEM_W-1:0]  offs;
    logic              cycleOk;

    assign baseW = winBase[w*ADDR_W +: ADDR_W];
    assign maskW = winMask[w*ADDR_W +: ADDR_W];
    assign xlW   = winXlate[w*ADDR_W +: MEM_W];
    assign offs  = effAddr[MEM_W-1:0] & maskW[MEM_W-1:0];

    if (w == WIN_WIDE) begin : g_wide
      assign cycleOk = reqDac;
    end else begin : g_narrow
      assign cycleOk = !reqDac;
    end

    assign matchVec[w] = winEnable[w] && cycleOk &&
                         (((effAddr ^ baseW) & ~maskW) == '0);

    if (w == WIN_SG) begin : g_sg
      assign mapped[w] = offs;
    end else begin : g_direct
      assign mapped[w] = xlW + offs;
    end
  end

  assign memNext = strobe.hit ? mapped[strobe.winIdx] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
    end else if (strobe.load) begin
      memAddr <= memNext;
    end
  end
endmodule

// File: rtl/pciwin_ctrl.sv
`timescale 1ns/1ps
module pciwin_ctrl
  import pciwin_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [NUM_WIN-1:0] matchVec,
  output ctrlStrobe_t        strobe,
  output logic               outValid,
  output logic               outHit,
  output logic               outNoHit,
  output logic               outFwdSg,
  output logic [IDX_W-1:0]   outWinIdx
);
  logic             anyHit;
  logic [IDX_W-1:0] selIdx;

  // lowest index wins: scan from the top so lower entries overwrite
  always_comb begin
    anyHit = 1'b0;
    selIdx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        anyHit = 1'b1;
        selIdx = IDX_W'(i);
      end
    end
  end

  assign strobe.load   = reqValid;
  assign strobe.hit    = anyHit;
  assign strobe.winIdx = selIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outHit    <= 1'b0;
      outNoHit  <= 1'b0;
      outFwdSg  <= 1'b0;
      outWinIdx <= '0;
    end else begin
      outValid <= reqValid;
      outHit   <= reqValid && anyHit;
      outNoHit <= reqValid && !anyHit;
      outFwdSg <= reqValid && anyHit && (selIdx == IDX_W'(WIN_SG));
      if (reqValid) outWinIdx <= selIdx;
    end
  end
endmodule

// File: rtl/pciwin_decoder.sv
`timescale 1ns/1ps
module pciwin_decoder
  import pciwin_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int MEM_W  = 40
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic                      reqDac,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [NUM_WIN-1:0]        winEnable,
  input  logic [NUM_WIN*ADDR_W-1:0] winBase,
  input  logic [NUM_WIN*ADDR_W-1:0] winMask,
  input  logic [NUM_WIN*ADDR_W-1:0] winXlate,
  output logic                      outValid,
  output logic                      outHit,
  output logic                      outNoHit,
  output logic                      outFwdSg,
  output logic [IDX_W-1:0]          outWinIdx,
  output logic [MEM_W-1:0]          outMemAddr
);
  ctrlStrobe_t        strobe;
  logic [NUM_WIN-1:0] matchVec;

  pciwin_datapath #(.ADDR_W(ADDR_W), .MEM_W(MEM_W)) i_datapath (
    .clk(clk), .rstN(rstN), .reqDac(reqDac), .reqAddr(reqAddr),
    .winEnable(winEnable), .winBase(winBase), .winMask(winMask),
    .winXlate(winXlate), .strobe(strobe), .matchVec(matchVec),
    .memAddr(outMemAddr)
  );

  pciwin_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .matchVec(matchVec),
    .strobe(strobe), .outValid(outValid), .outHit(outHit),
    .outNoHit(outNoHit), .outFwdSg(outFwdSg), .outWinIdx(outWinIdx)
  );
endmodule

// File: rtl/pciwin_decoder_chk.sv
`timescale 1ns/1ps
module pciwin_decoder_chk
  import pciwin_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int MEM_W  = 40
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqDac,
  input logic [NUM_WIN-1:0]   winEnable,
  input logic                 outValid,
  input logic                 outHit,
  input logic                 outNoHit,
  input logic                 outFwdSg,
  input logic [IDX_W-1:0]     outWinIdx,
  input logic [MEM_W-1:0]     outMemAddr
);
  // R2
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);
  // R2
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid);
  // R8
  hit_nohit_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outHit != outNoHit));
  // R7
  fwd_only_sg_chk: assert property (@(posedge clk) disable iff (!rstN)
    outFwdSg |-> (outHit && outWinIdx == IDX_W'(WIN_SG)));
  // R5
  dac_only_wide_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqDac) |=> (outNoHit || outWinIdx == IDX_W'(WIN_WIDE)));
  // R5
  sac_never_wide_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqDac) |=> (outNoHit || outWinIdx != IDX_W'(WIN_WIDE)));
  // R3
  all_disabled_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && winEnable == '0) |=> outNoHit);
  // R9
  idle_flags_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!outHit && !outNoHit && !outFwdSg));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(outWinIdx) && $stable(outMemAddr)));
endmodule

bind pciwin_decoder pciwin_decoder_chk #(.ADDR_W(ADDR_W), .MEM_W(MEM_W)) i_chk (.*);

// File: tb/test_pciwin_decoder.sv
`timescale 1ns/1ps
module test_pciwin_decoder;
  localparam int AW = 64;
  localparam int MW = 40;
  localparam int NW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqDac = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [NW-1:0] winEnable = '0;
  logic [AW-1:0] baseA [NW];
  logic [AW-1:0] maskA [NW];
  logic [AW-1:0] xlA   [NW];
  logic [NW*AW-1:0] winBase, winMask, winXlate;
  logic outValid, outHit, outNoHit, outFwdSg;
  logic [1:0] outWinIdx;
  logic [MW-1:0] outMemAddr;

  int checks = 0;
  int errors = 0;
  bit cmpEn = 1'b0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      winBase[w*AW +: AW]  = baseA[w];
      winMask[w*AW +: AW]  = maskA[w];
      winXlate[w*AW +: AW] = xlA[w];
    end
  end

  pciwin_decoder i_pciwin_decoder (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqDac(reqDac),
    .reqAddr(reqAddr), .winEnable(winEnable), .winBase(winBase),
    .winMask(winMask), .winXlate(winXlate), .outValid(outValid),
    .outHit(outHit), .outNoHit(outNoHit), .outFwdSg(outFwdSg),
    .outWinIdx(outWinIdx), .outMemAddr(outMemAddr)
  );

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: returns winning window or -1
  function automatic int refDecode(input logic dac, input logic [63:0] a,
                                   output logic [MW-1:0] mem);
    logic [63:0] ea;
    ea = dac ? a : {32'h0, a[31:0]};
    mem = '0;
    for (int w = 0; w < NW; w++) begin
      if (winEnable[w] && (dac == (w == 3)) &&
          ((ea & ~maskA[w]) == (baseA[w] & ~maskA[w]))) begin
        if (w == 1) mem = MW'(ea & maskA[w]);
        else        mem = MW'(xlA[w] + (ea & maskA[w]));
        return w;
      end
    end
    return -1;
  endfunction

  logic expValid, expHit, expNoHit, expFwd;
  logic [1:0] expIdx;
  logic [MW-1:0] expMem;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expValid <= 0; expHit <= 0; expNoHit <= 0; expFwd <= 0;
      expIdx <= 0; expMem <= 0;
    end else begin
      expValid <= reqValid;
      if (reqValid) begin
        int w;
        logic [MW-1:0] m;
        w = refDecode(reqDac, reqAddr, m);
        expHit   <= (w >= 0);
        expNoHit <= (w < 0);
        expFwd   <= (w == 1);
        expIdx   <= (w >= 0) ? 2'(w) : 2'd0;
        expMem   <= m;
      end else begin
        expHit <= 0; expNoHit <= 0; expFwd <= 0;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmpEn) begin
      string tg;
      tg = !expValid ? "R9" : expNoHit ? "R8" : expFwd ? "R7" : "R6";
      check("R2", "outValid", 64'(outValid), 64'(expValid));
      check(tg, "outHit", 64'(outHit), 64'(expHit));
      check(tg, "outNoHit", 64'(outNoHit), 64'(expNoHit));
      check(tg, "outFwdSg", 64'(outFwdSg), 64'(expFwd));
      check(tg, "outWinIdx", 64'(outWinIdx), 64'(expIdx));
      check(tg, "outMemAddr", 64'(outMemAddr), 64'(expMem));
    end
  end

  task automatic doReq(string tag, logic dac, logic [63:0] a,
                       logic eHit, logic [1:0] eIdx, logic [MW-1:0] eMem);
    reqValid = 1; reqDac = dac; reqAddr = a;
    @(negedge clk);
    reqValid = 0;
    check(tag, "hit", 64'(outHit), 64'(eHit));
    check(tag, "noHit", 64'(outNoHit), 64'(!eHit));
    if (eHit) begin
      check(tag, "winIdx", 64'(outWinIdx), 64'(eIdx));
      check(tag, "memAddr", 64'(outMemAddr), 64'(eMem));
    end
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    baseA[0] = 64'h0080_0000;          maskA[0] = 64'h007F_FFFF; xlA[0] = 64'h0;
    baseA[1] = 64'h8000_0000;          maskA[1] = 64'h0FFF_FFFF; xlA[1] = 64'h55_0000_0000;
    baseA[2] = 64'h8000_0000;          maskA[2] = 64'h7FFF_FFFF; xlA[2] = 64'h10_0000_0000;
    baseA[3] = 64'h0000_0001_0000_0000; maskA[3] = 64'hFFFF_FFFF; xlA[3] = 64'h20_0000_0000;
    winEnable = 4'hF;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "outValid", 64'(outValid), 0);
    check("R1", "outHit", 64'(outHit), 0);
    check("R1", "outNoHit", 64'(outNoHit), 0);
    check("R1", "outFwdSg", 64'(outFwdSg), 0);
    check("R1", "outMemAddr", 64'(outMemAddr), 0);
    rstN = 1;
    @(negedge clk);
    check("R1", "outValid after release", 64'(outValid), 0);
    cmpEn = 1;

    // R6: legacy window direct map
    doReq("R6", 0, 64'h0000_0000_0080_0010, 1, 2'd0, 40'h10);
    // R5: upper half ignored in single-address cycle
    doReq("R5", 0, 64'hFFFF_FFFF_0080_0010, 1, 2'd0, 40'h10);
    // R5: dual-address with low-only address misses window 3
    doReq("R5", 1, 64'h0000_0000_0080_0010, 0, 2'd0, 40'h0);
    // R5: dual-address inside window 3
    doReq("R5", 1, 64'h0000_0001_0000_1234, 1, 2'd3, 40'h20_0000_1234);
    // R4 R7: overlap, window 1 wins and forwards the offset
    doReq("R4", 0, 64'h8000_0040, 1, 2'd1, 40'h40);
    // R6: beyond window 1, window 2 direct maps
    doReq("R6", 0, 64'h9000_0008, 1, 2'd2, 40'h10_1000_0008);
    // R3: disable window 1, same address now falls to window 2
    winEnable = 4'b1101;
    doReq("R3", 0, 64'h8000_0040, 1, 2'd2, 40'h10_0000_0040);
    // R3: disabled window 0 never matches
    winEnable = 4'b1110;
    doReq("R3", 0, 64'h0080_0010, 0, 2'd0, 40'h0);
    // R8: address outside all windows
    winEnable = 4'hF;
    doReq("R8", 0, 64'h0000_1000, 0, 2'd0, 40'h0);

    // random stream, compared each cycle by the model
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      reqValid = ($urandom % 4) != 0;
      reqDac = ($urandom % 3) == 0;
      reqAddr = {$urandom, $urandom};
      case ($urandom % 5)
        0: reqAddr[31:0] = 32'h0080_0000 | (r & 32'h007F_FFFF);
        1: reqAddr[31:0] = 32'h8000_0000 | (r & 32'h0FFF_FFFF);
        2: reqAddr[31:0] = 32'h8000_0000 | (r & 32'h7FFF_FFFF);
        3: reqAddr[63:32] = 32'h1;
        default: ;
      endcase
      if (($urandom % 50) == 0) winEnable = 4'($urandom);
      @(negedge clk);
    end
    reqValid = 0;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule